// File: doc/BRIEF.md
# Pipelined Signed-Digit by Binary Multiplier

This block multiplies an N-digit radix-2 signed-digit (SD) multiplicand by an N-bit unsigned binary number. Each SD digit takes one of the values -1, 0 or +1 and is carried on two wires, a positive channel and a negative channel. The multiply is spread over a linear pipeline of N stages. Every stage holds one carry-free SD-plus-binary adder. The multiplicand digit for that stage picks one of three actions for the binary operand on the running partial sum: add it, subtract it, or add nothing.

Digits are consumed from the least significant end. After each stage the lowest digit of the partial sum is final. It is retired into the low half of the product, and the rest of the partial sum moves down one digit position. The operands and the retired digits travel with each operation, so a new multiply can enter on every clock while up to N others are in flight. The 2N-digit SD product leaves the last stage with its own valid flag.

Top module: `sd_bin_mult`

## Requirements
- R1: A multiplicand digit is encoded as (pos, neg) = (0,0) for 0, (1,0) for +1 and (0,1) for -1. Digit i has weight 2^i. Product digits use the same encoding with weights 2^0 to 2^(2N-1). The binary operand is unsigned.
- R2: When `out_valid` is high, the value of the product digits equals the value of the accepted multiplicand times the accepted binary operand.
- R3: `out_valid` is high exactly N clock cycles after a cycle in which `in_valid` was high, and low otherwise.
- R4: Operations issued on consecutive cycles produce results on consecutive cycles, in issue order, with no stall and no loss.
- R5: No product digit ever carries the unused code (1,1).
- R6: A multiplicand digit with the unused code (1,1) is treated as 0, so its stage adds nothing.
- R7: While `rst_n` is low, `out_valid` is low and every product digit is (0,0).
- R8: When the accepted multiplicand has value 0 or the binary operand is 0, every product digit is (0,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are present this cycle |
| a_pos | input | N | Positive channel of the SD multiplicand |
| a_neg | input | N | Negative channel of the SD multiplicand |
| b_in | input | N | Unsigned binary multiplier |
| out_valid | output | 1 | Product is present this cycle |
| p_pos | output | 2N | Positive channel of the SD product |
| p_neg | output | 2N | Negative channel of the SD product |

## Verification
On every cycle the bound checker checks four things. The output valid follows the input valid N cycles later. No product digit carries the unused code. The value of each product matches the value of the operands that entered N cycles earlier. A zero operand gives an all-zero digit pattern. The treatment of the unused multiplicand code can only be seen in the bench's scenarios. So can the reset state, back-to-back ordering over a long stream, and full coverage of every 4-digit multiplicand against every binary operand.

// File: rtl/sd_bin_mult.sv
module sd_bin_mult #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N-1:0]   a_pos,
  input  logic [N-1:0]   a_neg,
  input  logic [N-1:0]   b_in,
  output logic           out_valid,
  output logic [2*N-1:0] p_pos,
  output logic [2*N-1:0] p_neg
);

  logic         v_q  [N];
  logic [N-1:0] r_pq [N];
  logic [N-1:0] r_nq [N];
  logic [N-1:0] l_pq [N];
  logic [N-1:0] l_nq [N];
  logic [N-1:0] a_pq [N-1];
  logic [N-1:0] a_nq [N-1];
  logic [N-1:0] b_q  [N-1];

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic         vi;
    logic [N-1:0] ap, an, bi, rp, rn, lp, ln;
    logic         dadd, dsub;
    logic [N-1:0] bb, xp, xn, cy, zn;
    logic [N:0]   cin, zv, sp, sn, yp, yn;

    if (k == 0) begin : g_head
      assign vi = in_valid;
      assign ap = a_pos;
      assign an = a_neg;
      assign bi = b_in;
      assign rp = '0;
      assign rn = '0;
      assign lp = '0;
      assign ln = '0;
    end else begin : g_link
      assign vi = v_q[k-1];
      assign ap = a_pq[k-1];
      assign an = a_nq[k-1];
      assign bi = b_q[k-1];
      assign rp = r_pq[k-1];
      assign rn = r_nq[k-1];
      assign lp = l_pq[k-1];
      assign ln = l_nq[k-1];
    end

    assign dadd = ap[k] & ~an[k];
    assign dsub = an[k] & ~ap[k];
    assign bb   = (dadd | dsub) ? bi : '0;
    assign xp   = dsub ? rn : rp;
    assign xn   = dsub ? rp : rn;
    assign cy   = xp | (~xn & bb);
    assign zn   = (xp | xn) ^ bb;
    assign cin  = {cy, 1'b0};
    assign zv   = {1'b0, zn};
    assign sp   = cin & ~zv;
    assign sn   = zv & ~cin;
    assign yp   = dsub ? sn : sp;
    assign yn   = dsub ? sp : sn;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[k]  <= 1'b0;
        r_pq[k] <= '0;
        r_nq[k] <= '0;
        l_pq[k] <= '0;
        l_nq[k] <= '0;
      end else begin
        v_q[k]  <= vi;
        r_pq[k] <= yp[N:1];
        r_nq[k] <= yn[N:1];
        l_pq[k] <= lp | ({{(N-1){1'b0}}, yp[0]} << k);
        l_nq[k] <= ln | ({{(N-1){1'b0}}, yn[0]} << k);
      end
    end

    if (k < N-1) begin : g_carry
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          a_pq[k] <= '0;
          a_nq[k] <= '0;
          b_q[k]  <= '0;
        end else begin
          a_pq[k] <= ap;
          a_nq[k] <= an;
          b_q[k]  <= bi;
        end
      end
    end
  end

  assign out_valid = v_q[N-1];
  assign p_pos     = {r_pq[N-1], l_pq[N-1]};
  assign p_neg     = {r_nq[N-1], l_nq[N-1]};

endmodule

// File: rtl/sd_bin_mult_chk.sv
module sd_bin_mult_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [N-1:0]   a_pos,
  input logic [N-1:0]   a_neg,
  input logic [N-1:0]   b_in,
  input logic           out_valid,
  input logic [2*N-1:0] p_pos,
  input logic [2*N-1:0] p_neg
);
  localparam int W = 2*N + 2;

  function automatic logic signed [W-1:0] in_value(input logic [N-1:0] dp, input logic [N-1:0] dn);
    logic signed [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (dp[i] && !dn[i]) acc = acc + (W'(1) << i);
      if (dn[i] && !dp[i]) acc = acc - (W'(1) << i);
    end
    return acc;
  endfunction

  function automatic logic signed [W-1:0] out_value(input logic [2*N-1:0] dp, input logic [2*N-1:0] dn);
    logic signed [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < 2*N; i++) begin
      if (dp[i]) acc = acc + (W'(1) << i);
      if (dn[i]) acc = acc - (W'(1) << i);
    end
    return acc;
  endfunction

  logic                hv [N];
  logic                hz [N];
  logic signed [W-1:0] hp [N];
  logic signed [W-1:0] av, bv;

  assign av = in_value(a_pos, a_neg);
  assign bv = W'(b_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        hv[i] <= 1'b0;
        hz[i] <= 1'b0;
        hp[i] <= '0;
      end
    end else begin
      hv[0] <= in_valid;
      hz[0] <= (av == 0) || (b_in == '0);
      hp[0] <= av * bv;
      for (int i = 1; i < N; i++) begin
        hv[i] <= hv[i-1];
        hz[i] <= hz[i-1];
        hp[i] <= hp[i-1];
      end
    end
  end

  assert_valid_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hv[N-1]);

  assert_no_illegal_digit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (p_pos & p_neg) == '0);

  assert_product_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_value(p_pos, p_neg) == hp[N-1]));

  assert_zero_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hz[N-1]) |-> (p_pos == '0 && p_neg == '0));

endmodule

bind sd_bin_mult sd_bin_mult_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_pos(a_pos), .a_neg(a_neg),
  .b_in(b_in), .out_valid(out_valid), .p_pos(p_pos), .p_neg(p_neg)
);

// File: tb/sim_sd_bin_mult.sv
module sim_sd_bin_mult;
  localparam int N = 4;
  localparam int DEPTH = 4096;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [N-1:0]   a_pos = '0, a_neg = '0, b_in = '0;
  logic           out_valid;
  logic [2*N-1:0] p_pos, p_neg;

  sd_bin_mult #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_pos(a_pos), .a_neg(a_neg),
    .b_in(b_in), .out_valid(out_valid), .p_pos(p_pos), .p_neg(p_neg)
  );

  always #2 clk = ~clk;

  int    checks = 0, failures = 0;
  int    cyc = 0, ni = 0, no = 0;
  bit    done = 1'b0;
  longint ev [DEPTH];
  int    et [DEPTH];
  bit    ez [DEPTH];
  bit    eb [DEPTH];

  function automatic longint dig_in(input logic [N-1:0] dp, input logic [N-1:0] dn);
    longint acc = 0;
    for (int i = 0; i < N; i++) begin
      if (dp[i] && !dn[i]) acc += (64'sd1 << i);
      if (dn[i] && !dp[i]) acc -= (64'sd1 << i);
    end
    return acc;
  endfunction

  function automatic longint dig_out(input logic [2*N-1:0] dp, input logic [2*N-1:0] dn);
    longint acc = 0;
    for (int i = 0; i < 2*N; i++) begin
      if (dp[i]) acc += (64'sd1 << i);
      if (dn[i]) acc -= (64'sd1 << i);
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic sample();
    if (out_valid) begin
      if (no >= ni) begin
        chk(1'b0, "R3 unexpected out_valid", no, ni);
      end else begin
        chk(dig_out(p_pos, p_neg) == ev[no],
            eb[no] ? "R6 product with unused digit code" : "R2 product value",
            dig_out(p_pos, p_neg), ev[no]);
        chk(cyc - et[no] == N,
            (no > 0 && et[no] == et[no-1] + 1) ? "R4 back-to-back latency" : "R3 latency",
            cyc - et[no], N);
        chk((p_pos & p_neg) == '0, "R5 no (1,1) product digit", longint'(p_pos & p_neg), 0);
        if (ez[no])
          chk(p_pos == '0 && p_neg == '0, "R8 zero operand pattern",
              longint'({p_pos, p_neg}), 0);
        no++;
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    sample();
  endtask

  task automatic issue(input logic [N-1:0] ap, input logic [N-1:0] an,
                       input logic [N-1:0] bv, input bit v);
    step();
    in_valid = v;
    a_pos = ap;
    a_neg = an;
    b_in  = bv;
    if (v) begin
      ev[ni] = dig_in(ap, an) * longint'(bv);
      et[ni] = cyc;
      ez[ni] = (dig_in(ap, an) == 0) || (bv == '0);
      eb[ni] = (ap & an) != '0;
      ni++;
    end
  endtask

  initial begin
    void'($urandom(32'h1d5e_ed07));
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
      chk(p_pos == '0 && p_neg == '0, "R7 reset product digits", longint'({p_pos, p_neg}), 0);
    end
    rst_n = 1'b1;

    // R1 exhaustive: every multiplicand digit pattern against every multiplier
    for (int idx = 0; idx < 81; idx++) begin
      for (int bv = 0; bv < 16; bv++) begin
        logic [N-1:0] ap, an;
        int t;
        t = idx;
        ap = '0;
        an = '0;
        for (int d = 0; d < N; d++) begin
          if (t % 3 == 1) ap[d] = 1'b1;
          if (t % 3 == 2) an[d] = 1'b1;
          t = t / 3;
        end
        issue(ap, an, N'(bv), 1'b1);
      end
    end

    // R6 directed: unused code in every digit, and in single positions
    issue('1, '1, '1, 1'b1);
    issue(4'b0101, 4'b0111, 4'b1011, 1'b1);
    issue(4'b1000, 4'b1001, 4'b1111, 1'b1);
    // extremes
    issue('1, '0, '1, 1'b1);
    issue('0, '1, '1, 1'b1);
    issue(4'b0101, 4'b1010, '1, 1'b1);
    issue('0, '0, '0, 1'b0);
    issue('0, '0, '0, 1'b0);

    // random stream with gaps
    for (int k = 0; k < 500; k++) begin
      logic [N-1:0] ap, an, bv;
      ap = N'($urandom);
      an = N'($urandom);
      bv = N'($urandom);
      issue(ap, an, bv, ($urandom % 4) != 0);
    end

    for (int k = 0; k < N + 3; k++) issue('0, '0, '0, 1'b0);
    chk(no == ni, "R4 every issued multiply delivered", no, ni);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", no, ni);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule